// File: doc/BRIEF.md
# Counted Loop-Back Redirect Unit

This unit supports an instruction that announces a loop in advance. When such an instruction reaches the execute-side stage, the unit captures three things: the instruction's own address, its count field, and the number of pipeline levels that are occupied at that moment. It then counts instructions as they enter the first pipeline stage. When the number of counted entries brings the remaining count down to the captured level count, the unit raises a one-cycle redirect. The redirect carries the saved address to the fetch address generator. The block of instructions at the loop start can then be fetched from memory before the closing branch executes.

The level offset accounts for instructions that are already in the pipe when the count is loaded, so that the redirect lines up with the real loop end. If the count is already at or below the level count when it is loaded, the redirect fires straight away. A new load replaces whatever countdown is in progress. Executing the branch itself is handled elsewhere.

Top module: `loopback_trigger`

## Requirements
- R1: After reset `redirect_o` is low, and it stays low for as long as no load has been accepted, whatever `entry_i` does.
- R2: A load captures `load_addr_i`. Whenever `redirect_o` is high, `redirect_addr_o` equals the address of the most recent load.
- R3: While a countdown is pending, each cycle with `entry_i` high lowers the remaining count by exactly one. An entry in the same cycle as a load is not counted.
- R4: With count N and level count L where N > L, `redirect_o` is high in the cycle that follows the clock edge at which the (N − L)-th counted entry is taken, and it is not high before that cycle.
- R5: If N ≤ L at load time, `redirect_o` is high in the cycle right after the load, with no entries needed.
- R6: `redirect_o` is high for a single cycle per load. After that the unit is idle, and no entries produce another redirect until the next load.
- R7: A load while a countdown is pending discards the old count, level count and address. The timing and address of the redirect follow only the new load.
- R8: The counter never wraps below zero. A count of zero loaded with a level count of zero gives exactly one redirect.
- R9: The level count is taken from `load_levels_i` only in a load cycle. Changing `load_levels_i` at other times does not change when the redirect fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Loop-announce instruction has reached the execute-side stage |
| load_count_i | input | CNT_W | Number of instructions before the branch back |
| load_addr_i | input | ADDR_W | Address of the loop-announce instruction |
| load_levels_i | input | LVL_W | Pipeline levels occupied at load time |
| entry_i | input | 1 | One instruction enters the first pipeline stage |
| redirect_o | output | 1 | One-cycle request to refetch from the saved address |
| redirect_addr_o | output | ADDR_W | Saved loop-start address |

## Verification
The bench builds the unit with a 6-bit counter, a 3-bit level count and a 24-bit address. With these sizes the largest count (63) and the largest level offset (7) can both be reached within a short run, and counts at or below the offset turn up often. Random stimulus changes `load_levels_i` in most cycles and lands loads on pending countdowns. This exercises both the capture-only-at-load rule and the override rule, alongside directed runs at count zero and at the top of the count range.

// File: rtl/lb_pkg.sv
package lb_pkg;
   typedef enum logic {
      LB_IDLE  = 1'b0,
      LB_ARMED = 1'b1
   } lb_state_e;

   function automatic int lb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/lb_countdown.sv
module lb_countdown #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             at_floor;

   assign at_floor = (cnt_q == CNT_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && !at_floor) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/lb_capture.sv
module lb_capture #(
   parameter int ADDR_W = 24,
   parameter int LVL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LVL_W-1:0]  lvl_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [LVL_W-1:0]  lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         lvl_q  <= '0;
      end else if (load_i) begin
         addr_q <= addr_i;
         lvl_q  <= lvl_i;
      end
   end

   assign addr_o = addr_q;
   assign lvl_o  = lvl_q;
endmodule

// File: rtl/lb_fire.sv
module lb_fire #(
   parameter int CNT_W = 12,
   parameter int LVL_W = 3
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic             reach_o
);
   localparam int CMP_W = lb_pkg::lb_max(CNT_W, LVL_W);

   logic [CMP_W-1:0] cnt_w;
   logic [CMP_W-1:0] lvl_w;

   generate
      if (CNT_W == CMP_W) begin : g_cnt_wide
         assign cnt_w = cnt_i;
      end else begin : g_cnt_pad
         assign cnt_w = {{(CMP_W-CNT_W){1'b0}}, cnt_i};
      end
      if (LVL_W == CMP_W) begin : g_lvl_wide
         assign lvl_w = lvl_i;
      end else begin : g_lvl_pad
         assign lvl_w = {{(CMP_W-LVL_W){1'b0}}, lvl_i};
      end
   endgenerate

   // remaining minus level offset is zero or negative
   assign reach_o = (cnt_w <= lvl_w);
endmodule

// File: rtl/loopback_trigger.sv
module loopback_trigger #(
   parameter int CNT_W  = 12,
   parameter int ADDR_W = 24,
   parameter int LVL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CNT_W-1:0]  load_count_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic [LVL_W-1:0]  load_levels_i,
   input  logic              entry_i,
   output logic              redirect_o,
   output logic [ADDR_W-1:0] redirect_addr_o
);
   import lb_pkg::*;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("loopback_trigger: CNT_W out of range");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("loopback_trigger: ADDR_W must be positive");
      end
      if (LVL_W < 1 || LVL_W > CNT_W) begin : g_bad_lvl
         $error("loopback_trigger: LVL_W must be 1..CNT_W");
      end
   endgenerate

   lb_state_e        state_q;
   logic             armed;
   logic             reach;
   logic             fire;
   logic             dec;
   logic [CNT_W-1:0] cnt_q;
   logic [LVL_W-1:0] lvl_q;

   assign armed = (state_q == LB_ARMED);
   assign fire  = armed && reach;
   assign dec   = armed && entry_i && !reach && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LB_IDLE;
      end else if (load_i) begin
         state_q <= LB_ARMED;
      end else if (fire) begin
         state_q <= LB_IDLE;
      end
   end

   lb_countdown #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (load_count_i),
      .dec_i      (dec),
      .cnt_o      (cnt_q)
   );

   lb_capture #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .addr_i (load_addr_i),
      .lvl_i  (load_levels_i),
      .addr_o (redirect_addr_o),
      .lvl_o  (lvl_q)
   );

   lb_fire #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_fire (
      .cnt_i   (cnt_q),
      .lvl_i   (lvl_q),
      .reach_o (reach)
   );

   assign redirect_o = fire;
endmodule

// File: rtl/loopback_trigger_chk.sv
module loopback_trigger_chk #(
   parameter int CNT_W  = 12,
   parameter int ADDR_W = 24,
   parameter int LVL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [CNT_W-1:0]  load_count_i,
   input logic [ADDR_W-1:0] load_addr_i,
   input logic [LVL_W-1:0]  load_levels_i,
   input logic              entry_i,
   input logic              redirect_o,
   input logic [ADDR_W-1:0] redirect_addr_o,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              armed
);
   localparam int CMP_W = lb_pkg::lb_max(CNT_W, LVL_W);

   logic [CMP_W-1:0] cnt_x;
   logic [CMP_W-1:0] lvl_x;
   assign cnt_x = CMP_W'(load_count_i);
   assign lvl_x = CMP_W'(load_levels_i);

   assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (redirect_addr_o == $past(load_addr_i)));

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && entry_i && !load_i && !redirect_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_early_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (cnt_x <= lvl_x)) |=> redirect_o);

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !load_i) |=> !redirect_o);

   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !load_i) |=> !redirect_o);
endmodule

bind loopback_trigger loopback_trigger_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .load_i          (load_i),
   .load_count_i    (load_count_i),
   .load_addr_i     (load_addr_i),
   .load_levels_i   (load_levels_i),
   .entry_i         (entry_i),
   .redirect_o      (redirect_o),
   .redirect_addr_o (redirect_addr_o),
   .cnt_q           (cnt_q),
   .armed           (armed)
);

// File: tb/loopback_trigger_tb_top.sv
`timescale 1ns/1ps
module loopback_trigger_tb_top;
   localparam int CNT_W  = 6;
   localparam int ADDR_W = 24;
   localparam int LVL_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_i = 1'b0;
   logic [CNT_W-1:0]  load_count_i = '0;
   logic [ADDR_W-1:0] load_addr_i = '0;
   logic [LVL_W-1:0]  load_levels_i = '0;
   logic              entry_i = 1'b0;
   logic              redirect_o;
   logic [ADDR_W-1:0] redirect_addr_o;

   int checks = 0;
   int failures = 0;

   // reference model state
   bit             m_armed = 1'b0;
   int             m_rem = 0;
   bit [ADDR_W-1:0] m_addr = '0;

   always #4 clk = ~clk;

   loopback_trigger #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .load_i          (load_i),
      .load_count_i    (load_count_i),
      .load_addr_i     (load_addr_i),
      .load_levels_i   (load_levels_i),
      .entry_i         (entry_i),
      .redirect_o      (redirect_o),
      .redirect_addr_o (redirect_addr_o)
   );

   function automatic bit exp_fire();
      return m_armed && (m_rem <= 0);
   endfunction

   task automatic check_out(input string tag);
      bit ef;
      ef = exp_fire();
      checks++;
      if (redirect_o !== ef) begin
         failures++;
         $display("FAIL %s redirect_o actual=%0b expected=%0b", tag, redirect_o, ef);
      end
      if (ef) begin
         checks++;
         if (redirect_addr_o !== m_addr) begin
            failures++;
            $display("FAIL %s redirect_addr_o actual=%h expected=%h", tag, redirect_addr_o, m_addr);
         end
      end
   endtask

   // drive one cycle (called at a negedge), update model at posedge, check at next negedge
   task automatic cyc(input string tag, input bit ld, input int n, input bit [ADDR_W-1:0] a,
                      input int lv, input bit en);
      bit fire_now;
      load_i        = ld;
      load_count_i  = CNT_W'(n);
      load_addr_i   = a;
      load_levels_i = LVL_W'(lv);
      entry_i       = en;
      fire_now = exp_fire();
      @(posedge clk);
      if (ld) begin
         m_armed = 1'b1;
         m_rem   = n - lv;
         m_addr  = a;
      end else if (fire_now) begin
         m_armed = 1'b0;
      end else if (m_armed && en) begin
         m_rem = m_rem - 1;
      end
      @(negedge clk);
      check_out(tag);
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit [31:0] seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      checks++;
      if (redirect_o !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset redirect_o actual=%0b expected=0", redirect_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1: entries without any load never redirect
      for (int i = 0; i < 6; i++) cyc("R1", 0, 0, 24'h0, i % 8, 1);

      // R3/R4: N=5, L=2, entry in load cycle is ignored; fires after 3 entries
      cyc("R3", 1, 5, 24'h00A1B0, 2, 1);
      for (int i = 0; i < 5; i++) cyc("R4", 0, 0, 24'h0, 2, (i != 1));
      // R6: no more redirects after the pulse
      for (int i = 0; i < 6; i++) cyc("R6", 0, 0, 24'h0, 0, 1);

      // R5: N=1, L=3 fires next cycle without entries
      cyc("R5", 1, 1, 24'h123450, 3, 0);
      cyc("R5", 0, 0, 24'h0, 3, 0);
      cyc("R6", 0, 0, 24'h0, 3, 0);

      // R7: pending countdown replaced by a new load
      cyc("R7", 1, 10, 24'h0BEEF0, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R7", 0, 0, 24'h0, 0, 1);
      cyc("R7", 1, 2, 24'h0C0DE8, 0, 0);
      for (int i = 0; i < 4; i++) cyc("R7", 0, 0, 24'h0, 0, 1);

      // R8: zero count, zero levels: exactly one redirect, no wrap
      cyc("R8", 1, 0, 24'h000008, 0, 1);
      for (int i = 0; i < 8; i++) cyc("R8", 0, 0, 24'h0, 0, 1);

      // R8: top of range, N=63 L=7 -> 56 entries
      cyc("R8", 1, 63, 24'hFFFFF8, 7, 0);
      for (int i = 0; i < 60; i++) cyc("R4", 0, 0, 24'h0, 7, 1);

      // R9: levels input changes after load have no effect
      cyc("R9", 1, 6, 24'h055550, 1, 0);
      for (int i = 0; i < 8; i++) cyc("R9", 0, 0, 24'h0, 7 - (i % 8), 1);

      // R2 and the rest: random mix
      for (int i = 0; i < 4000; i++) begin
         bit ld;
         int n;
         ld = ($urandom % 16) == 0;
         n  = (($urandom % 4) == 0) ? int'($urandom % 64) : int'($urandom % 14);
         cyc("R2", ld, n, ADDR_W'({$urandom} & 32'hFFFFF8), int'($urandom % 8),
             ($urandom % 3) != 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule